// File: doc/BRIEF.md
# DDR2 Command-to-Data Latency Scheduler

This block follows the read and write commands that a DDR2 controller sends to the memory. For each command it predicts the clock cycles in which the data bus and the data strobe will carry that command's burst. It works out the read latency as the programmed additive latency plus the CAS latency. The write latency is one cycle less than the read latency. Each accepted command sets a read-data or write-data window flag. The flag rises exactly one latency after the command and stays high for half the burst length in cycles, because data moves on both clock edges.

The block also checks two timing rules. A read or write that reaches an opened bank before the activate-to-column delay has run out produces a one-cycle violation pulse. A command whose data window would collide with a window already scheduled in the other direction produces a one-cycle overlap pulse. The latency settings and the burst length are sampled together with each command, so a window that is already scheduled is not affected by a later change of settings. Commands and settings are plain control pins with no handshake: the memory command bus cannot be stalled, so the block has no back-pressure, and every strobe that is high at a clock edge is taken.

Top module: `ddr2_lat_sched`

## Requirements
- R1: A read issued in cycle 0 raises `rd_win_o` in cycle RL, where RL is the clamped additive latency plus the clamped CAS latency.
- R2: A write issued in cycle 0 raises `wr_win_o` in cycle WL = RL - 1.
- R3: Each window stays high for 2 cycles when `bl8_i` is 0 (burst of 4) and for 4 cycles when `bl8_i` is 1 (burst of 8), and then falls.
- R4: Additive latency values above 4 are treated as 4. CAS latency values below 3 are treated as 3, and values above 6 are treated as 6.
- R5: A read or write in cycle c to a bank whose most recent activate was in cycle a, with c - a < TRCD, pulses `trcd_err_o` high in cycle c + 1.
- R6: No violation is flagged for a command to a bank that has not been activated since reset, or for a command issued exactly TRCD cycles after the activate.
- R7: When a new command's window shares at least one cycle with a window in the opposite direction, whether already scheduled or issued in the same cycle, `ovl_err_o` is high in the cycle after the command.
- R8: Windows in the same direction merge without error. Reads in cycles 0 and 2 with burst 4 give one unbroken window from cycle RL to RL+3.
- R9: While reset is asserted and in the first cycle after it, all outputs are low and no bank counts as activated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| al_i | input | 3 | Additive latency setting |
| cl_i | input | 3 | CAS latency setting |
| bl8_i | input | 1 | 1 selects burst of 8, 0 selects burst of 4 |
| act_i | input | 1 | Activate command strobe |
| act_bank_i | input | BANK_W | Bank being activated |
| rd_i | input | 1 | Read command strobe |
| wr_i | input | 1 | Write command strobe |
| cmd_bank_i | input | BANK_W | Bank of the read or write |
| rd_win_o | output | 1 | Read data occupies the bus in this cycle |
| wr_win_o | output | 1 | Write data occupies the bus in this cycle |
| trcd_err_o | output | 1 | Column command came too soon after activate |
| ovl_err_o | output | 1 | Read and write windows collide |

## Verification
The bench builds the block with four banks and an activate-to-column delay of 3 cycles. With these values the early case (2 cycles) and the boundary case (exactly 3 cycles) both fall within a few cycles of the activate. The pending-window depth keeps its default, which is sized for the largest latency of 10 plus a burst of 8. This lets the bench drive clamped settings out to that latency and check a window arriving at the far end of the shift register.

// File: rtl/ddr2_sched_pkg.sv
package ddr2_sched_pkg;
  localparam int AL_MAX   = 4;
  localparam int CL_MIN   = 3;
  localparam int CL_MAX   = 6;
  localparam int BURST_CYC_MAX = 4;
  localparam int LAT_W    = 4;
  typedef logic [LAT_W-1:0] lat_t;
endpackage

// File: rtl/ddr2_lat_calc.sv
module ddr2_lat_calc
  import ddr2_sched_pkg::*;
(
  input  logic [2:0] al_i,
  input  logic [2:0] cl_i,
  output lat_t       rl_o,
  output lat_t       wl_o
);
  logic [2:0] al_c;
  logic [2:0] cl_c;

  always_comb begin
    al_c = (al_i > 3'(AL_MAX)) ? 3'(AL_MAX) : al_i;
    if (cl_i < 3'(CL_MIN))      cl_c = 3'(CL_MIN);
    else if (cl_i > 3'(CL_MAX)) cl_c = 3'(CL_MAX);
    else                        cl_c = cl_i;
    rl_o = {1'b0, al_c} + {1'b0, cl_c};
    wl_o = rl_o - lat_t'(1);
  end
endmodule

// File: rtl/ddr2_win_shift.sv
module ddr2_win_shift
  import ddr2_sched_pkg::*;
#(
  parameter int DEPTH = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire_i,
  input  lat_t             lat_i,
  input  logic             bl8_i,
  output logic [DEPTH-1:0] mask_o,
  output logic [DEPTH-1:0] pend_o,
  output logic             win_o
);
  logic [DEPTH-1:0] pend_q;
  int               len;
  int               lo;

  // bit p of the mask marks the cycle p+1 after the command
  always_comb begin
    len = bl8_i ? 4 : 2;
    lo  = int'(lat_i);
    for (int i = 0; i < DEPTH; i++) begin
      mask_o[i] = fire_i && (i + 1 >= lo) && (i + 1 < lo + len);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= (pend_q >> 1) | mask_o;
  end

  assign pend_o = pend_q;
  assign win_o  = pend_q[0];
endmodule

// File: rtl/ddr2_trcd_track.sv
module ddr2_trcd_track #(
  parameter int NBANK = 8,
  parameter int TRCD  = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     act_i,
  input  logic [$clog2(NBANK)-1:0] act_bank_i,
  input  logic                     chk_i,
  input  logic [$clog2(NBANK)-1:0] chk_bank_i,
  output logic                     early_o
);
  localparam int CW = $clog2(TRCD + 1);

  logic [NBANK-1:0] open_q;
  logic [CW-1:0]    age_q [NBANK];
  logic [NBANK-1:0] young;

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        open_q[b] <= 1'b0;
        age_q[b]  <= '0;
      end else if (act_i && act_bank_i == b[$clog2(NBANK)-1:0]) begin
        open_q[b] <= 1'b1;
        age_q[b]  <= CW'(1);
      end else if (age_q[b] < CW'(TRCD)) begin
        age_q[b]  <= age_q[b] + CW'(1);
      end
    end
    assign young[b] = open_q[b] && (age_q[b] < CW'(TRCD));
  end

  assign early_o = chk_i && young[chk_bank_i];
endmodule

// File: rtl/ddr2_lat_sched.sv
module ddr2_lat_sched
  import ddr2_sched_pkg::*;
#(
  parameter int NBANK  = 8,
  parameter int TRCD   = 4,
  parameter int BANK_W = $clog2(NBANK)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        al_i,
  input  logic [2:0]        cl_i,
  input  logic              bl8_i,
  input  logic              act_i,
  input  logic [BANK_W-1:0] act_bank_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [BANK_W-1:0] cmd_bank_i,
  output logic              rd_win_o,
  output logic              wr_win_o,
  output logic              trcd_err_o,
  output logic              ovl_err_o
);
  localparam int DEPTH = AL_MAX + CL_MAX + BURST_CYC_MAX - 1;

  lat_t             rl, wl;
  lat_t             lat   [2];
  logic [1:0]       fire;
  logic [1:0]       win;
  logic [DEPTH-1:0] mask  [2];
  logic [DEPTH-1:0] pend  [2];
  logic             early;
  logic             clash;

  ddr2_lat_calc u_lat (
    .al_i (al_i),
    .cl_i (cl_i),
    .rl_o (rl),
    .wl_o (wl)
  );

  assign fire = {wr_i, rd_i};
  assign lat[0] = rl;
  assign lat[1] = wl;

  // index 0 is the read direction, index 1 the write direction
  for (genvar d = 0; d < 2; d++) begin : g_dir
    ddr2_win_shift #(.DEPTH(DEPTH)) u_win (
      .clk    (clk),
      .rst_n  (rst_n),
      .fire_i (fire[d]),
      .lat_i  (lat[d]),
      .bl8_i  (bl8_i),
      .mask_o (mask[d]),
      .pend_o (pend[d]),
      .win_o  (win[d])
    );
  end

  ddr2_trcd_track #(.NBANK(NBANK), .TRCD(TRCD)) u_trcd (
    .clk        (clk),
    .rst_n      (rst_n),
    .act_i      (act_i),
    .act_bank_i (act_bank_i),
    .chk_i      (rd_i | wr_i),
    .chk_bank_i (cmd_bank_i),
    .early_o    (early)
  );

  always_comb begin
    clash = |(mask[0] & ((pend[1] >> 1) | mask[1]))
          | |(mask[1] & (pend[0] >> 1));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trcd_err_o <= 1'b0;
      ovl_err_o  <= 1'b0;
    end else begin
      trcd_err_o <= early;
      ovl_err_o  <= clash;
    end
  end

  assign rd_win_o = win[0];
  assign wr_win_o = win[1];
endmodule

// File: rtl/ddr2_lat_sched_chk.sv
module ddr2_lat_sched_chk (
  input logic clk,
  input logic rst_n,
  input logic rd_i,
  input logic wr_i,
  input logic rd_win_o,
  input logic wr_win_o,
  input logic trcd_err_o,
  input logic ovl_err_o
);
  localparam int SPAN = 13;
  logic [4:0] since_rd, since_wr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      since_rd <= 5'd31;
      since_wr <= 5'd31;
    end else begin
      since_rd <= rd_i ? 5'd1 : (since_rd == 5'd31 ? since_rd : since_rd + 5'd1);
      since_wr <= wr_i ? 5'd1 : (since_wr == 5'd31 ? since_wr : since_wr + 5'd1);
    end
  end

  // R1
  rd_win_bounded_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_win_o |-> (since_rd <= 5'(SPAN)));
  // R2
  wr_win_bounded_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_win_o |-> (since_wr <= 5'(SPAN)));
  // R3
  rd_win_min_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_win_o) |=> rd_win_o);
  // R3
  wr_win_min_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_win_o) |=> wr_win_o);
  // R5
  trcd_after_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(trcd_err_o) |-> $past(rd_i || wr_i));
  // R7
  ovl_after_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovl_err_o) |-> $past(rd_i || wr_i));
endmodule

bind ddr2_lat_sched ddr2_lat_sched_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rd_i       (rd_i),
  .wr_i       (wr_i),
  .rd_win_o   (rd_win_o),
  .wr_win_o   (wr_win_o),
  .trcd_err_o (trcd_err_o),
  .ovl_err_o  (ovl_err_o)
);

// File: tb/ddr2_lat_sched_test.sv
module ddr2_lat_sched_test;
  localparam int NB = 4;
  localparam int BW = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [2:0]    al_s = '0, cl_s = 3'd3;
  logic          bl8_s = 1'b0;
  logic          act_s = 1'b0, rd_s = 1'b0, wr_s = 1'b0;
  logic [BW-1:0] act_bank = '0, cmd_bank = '0;
  logic          rd_win, wr_win, trcd_err, ovl_err;
  int            nchk = 0, nfail = 0;

  always #5 clk = ~clk;

  ddr2_lat_sched #(.NBANK(NB), .TRCD(3)) uut (
    .clk(clk), .rst_n(rst_n), .al_i(al_s), .cl_i(cl_s), .bl8_i(bl8_s),
    .act_i(act_s), .act_bank_i(act_bank), .rd_i(rd_s), .wr_i(wr_s),
    .cmd_bank_i(cmd_bank), .rd_win_o(rd_win), .wr_win_o(wr_win),
    .trcd_err_o(trcd_err), .ovl_err_o(ovl_err)
  );

  task automatic check(bit ok, string req, int act, int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    check(rd_win == 0 && wr_win == 0, "R9", int'(rd_win | wr_win), 0);
    check(trcd_err == 0 && ovl_err == 0, "R9", int'(trcd_err | ovl_err), 0);
  endtask

  task automatic t_window(bit is_rd, int al, int cl, bit b8, int lat, string req);
    int len = b8 ? 4 : 2;
    @(negedge clk);
    al_s = 3'(al); cl_s = 3'(cl); bl8_s = b8; cmd_bank = 2'd0;
    if (is_rd) rd_s = 1'b1; else wr_s = 1'b1;
    @(negedge clk);
    rd_s = 1'b0; wr_s = 1'b0;
    for (int k = 1; k <= lat + len + 1; k++) begin
      bit exp = (k >= lat) && (k < lat + len);
      bit got = is_rd ? rd_win : wr_win;
      check(got == exp, req, int'(got), int'(exp));
      if (k == 1) check(trcd_err == 0, "R6", int'(trcd_err), 0);
      @(negedge clk);
    end
    idle(4);
  endtask

  task automatic t_trcd();
    // R5: activate bank 1, read 2 cycles later
    act_s = 1'b1; act_bank = 2'd1; @(negedge clk);
    act_s = 1'b0; @(negedge clk);
    rd_s = 1'b1; cmd_bank = 2'd1; @(negedge clk);
    rd_s = 1'b0;
    check(trcd_err == 1, "R5", int'(trcd_err), 1);
    @(negedge clk);
    check(trcd_err == 0, "R5", int'(trcd_err), 0);
    idle(14);
    // R6: activate bank 2, write exactly 3 cycles later
    act_s = 1'b1; act_bank = 2'd2; @(negedge clk);
    act_s = 1'b0; idle(2);
    wr_s = 1'b1; cmd_bank = 2'd2; @(negedge clk);
    wr_s = 1'b0;
    check(trcd_err == 0, "R6", int'(trcd_err), 0);
    idle(14);
    // R6: bank 3 never activated, read at once
    rd_s = 1'b1; cmd_bank = 2'd3; @(negedge clk);
    rd_s = 1'b0;
    check(trcd_err == 0, "R6", int'(trcd_err), 0);
    idle(14);
  endtask

  task automatic t_overlap();
    al_s = 3'd0; cl_s = 3'd3; bl8_s = 1'b0; cmd_bank = 2'd0;
    // read at 0 (cycles 3..4), write at 1 (cycles 3..4) -> collision
    rd_s = 1'b1; @(negedge clk);
    rd_s = 1'b0; wr_s = 1'b1;
    check(ovl_err == 0, "R7", int'(ovl_err), 0);
    @(negedge clk);
    wr_s = 1'b0;
    check(ovl_err == 1, "R7", int'(ovl_err), 1);
    idle(14);
    // read at 0, write at 4 (cycles 6..7) -> no collision
    rd_s = 1'b1; @(negedge clk);
    rd_s = 1'b0; idle(3);
    wr_s = 1'b1; @(negedge clk);
    wr_s = 1'b0;
    check(ovl_err == 0, "R7", int'(ovl_err), 0);
    idle(14);
  endtask

  task automatic t_seamless();
    al_s = 3'd0; cl_s = 3'd3; bl8_s = 1'b0; cmd_bank = 2'd0;
    rd_s = 1'b1; @(negedge clk);
    rd_s = 1'b0; @(negedge clk);
    rd_s = 1'b1; @(negedge clk);
    rd_s = 1'b0;
    // now in cycle 3
    for (int k = 3; k <= 8; k++) begin
      bit exp = (k >= 3) && (k <= 6);
      check(rd_win == exp, "R8", int'(rd_win), int'(exp));
      if (k == 3) check(ovl_err == 0, "R8", int'(ovl_err), 0);
      @(negedge clk);
    end
    idle(8);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_window(1'b1, 0, 3, 1'b0, 3, "R1");
    t_window(1'b1, 2, 3, 1'b1, 5, "R3");
    t_window(1'b0, 2, 3, 1'b0, 4, "R2");
    t_window(1'b0, 0, 3, 1'b1, 2, "R2");
    t_window(1'b1, 7, 7, 1'b1, 10, "R4");
    t_window(1'b1, 0, 1, 1'b0, 3, "R4");
    t_window(1'b0, 5, 0, 1'b0, 6, "R4");
    t_trcd();
    t_overlap();
    t_seamless();
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule